// File: doc/BRIEF.md
# Double-Precision Round and Pack Unit

This unit takes an unnormalised intermediate result from a floating-point datapath and turns it into a packed 64-bit binary64 word. The intermediate result has three parts: a sign, a signed unbiased exponent and a 56-bit mantissa. The mantissa holds the leading one at bit 55, then 52 fraction bits, then three extra bits at positions 2..0 that hold guard, round and sticky information. The unit rounds the value under one of four modes and can optionally flush tiny values. It denormalises values below the normal range, corrects the exponent when rounding carries out, and saturates overflow to infinity or to the largest finite value. It reports inexact, underflow and overflow flags alongside the result.

The block has one register stage. A beat presented with `in_valid` high appears on the outputs one cycle later with `out_valid` high. The outputs keep their last value while no new beat arrives. The reset is asynchronous and active low, and its release is synchronised inside the block. Exact zero inputs, and inputs whose bit 55 is clear, are outside the contract.

Top module: `dp_round_pack`

## Requirements
- R1: For an exact input (bits 2..0 zero) with exponent e in -1022..1023, the result is {sign, e+1023 as 11 bits, mantissa bits 54..3} and no flag is raised.
- R2: `in_mode` encodings are 0 = nearest with ties to even (add 3 plus mantissa bit 3), 1 = toward zero (add nothing), 2 = toward plus infinity (add 8 only when the sign is 0), 3 = toward minus infinity (add 8 only when the sign is 1). An increment is applied only when bits 2..0 are not all zero, and exactly then inexact is raised.
- R3: When rounding carries out above bit 55, the mantissa is shifted right by one and the exponent rises by one before packing.
- R4: When the exponent after rounding exceeds 1023, overflow and inexact are raised. The result is infinity (exponent field 0x7FF, fraction 0) for mode 0, for mode 2 with sign 0 and for mode 3 with sign 1. Otherwise it is the largest finite value (exponent field 0x7FE, fraction all ones) with the input sign.
- R5: When the exponent is below -1022 and `flush_en` is 1, underflow and inexact are raised. The result is the smallest denormal (only bit 0 of the fraction set) with the input sign for mode 2 with sign 0 and for mode 3 with sign 1. Otherwise it is a zero carrying the input sign.
- R6: When the exponent is -1023, flush is off and rounding the unshifted mantissa would carry out above bit 55, the value is not tiny. The result is the smallest normal number (exponent field 1, fraction 0) with the input sign, and only inexact is raised.
- R7: Any other tiny value is shifted right by (-1022 - exponent), with every bit shifted out ORed into bit 0; a deficit beyond the mantissa width leaves only that sticky bit. It is then rounded. Underflow is raised if it is inexact while bit 55 is clear. A result whose leading bit stays clear is packed with exponent field 0.
- R8: A result packed with exponent field 0 also raises underflow when `unf_mask` is 1, even if exact. When such a result is exact and `unf_mask` is 0, no flag is raised.
- R9: `out_valid` is high in the cycle after a cycle with `in_valid` high and low otherwise; result and flags change only one cycle after a cycle with `in_valid` high.
- R10: While reset is asserted, `out_valid`, `out_result` and all flags are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input beat present |
| in_sign | input | 1 | Sign of the value |
| in_exp | input | 13 | Signed unbiased exponent |
| in_mant | input | 56 | Mantissa, leading one at bit 55, guard/round/sticky at bits 2..0 |
| in_mode | input | 2 | Rounding mode (encoding in R2) |
| flush_en | input | 1 | Flush tiny values instead of denormalising |
| unf_mask | input | 1 | Raise underflow for every result packed with exponent field 0 |
| out_valid | output | 1 | Result beat present |
| out_result | output | 64 | Packed binary64 result |
| out_inexact | output | 1 | Result differs from the exact value |
| out_underflow | output | 1 | Tiny result flag |
| out_overflow | output | 1 | Exponent overflow flag |

## Verification
The bench goes after ties at the lowest result bit. A design that rounds ties away from zero would round an even mantissa up. It drives all-ones mantissas that carry out on rounding. A missing exponent correction there would produce a fraction of zero with the old exponent. It also covers the exponent -1023 carry case. A design that lacks the special check there returns a denormal with a false underflow instead of the smallest normal. Every (mode, sign) pair is driven into overflow and into flush, because a swapped table entry gives infinity instead of the largest finite value, or zero instead of the smallest denormal. Very large exponent deficits check that the shifter keeps the sticky bit rather than dropping the value to an exact zero.

// File: rtl/dp_rp_pkg.sv
package dp_rp_pkg;

  typedef enum logic [1:0] {
    RM_NEAR = 2'd0,
    RM_ZERO = 2'd1,
    RM_UP   = 2'd2,
    RM_DOWN = 2'd3
  } rmode_e;

  // Increment to add at the guard position; low holds mantissa bits 3..0.
  function automatic logic [3:0] rnd_inc(input logic sign, input rmode_e mode,
                                         input logic [3:0] low);
    logic [3:0] inc;
    inc = 4'd0;
    if (|low[2:0]) begin
      case (mode)
        RM_NEAR: inc = low[3] ? 4'd4 : 4'd3;
        RM_ZERO: inc = 4'd0;
        RM_UP:   inc = sign ? 4'd0 : 4'd8;
        RM_DOWN: inc = sign ? 4'd8 : 4'd0;
        default: inc = 4'd0;
      endcase
    end
    return inc;
  endfunction

endpackage

// File: rtl/dp_rp_tiny.sv
module dp_rp_tiny
  import dp_rp_pkg::*;
#(
  parameter int FRAC_W = 52,
  parameter int EXPF_W = 11,
  parameter int EXP_W  = 13
) (
  input  logic                          sign_i,
  input  rmode_e                        mode_i,
  input  logic signed [EXP_W-1:0]       exp_i,
  input  logic        [FRAC_W+3:0]      mant_i,
  output logic signed [EXP_W:0]         exp_o,
  output logic        [FRAC_W+3:0]      mant_o,
  output logic                          tiny_o,
  output logic                          edge_o
);
  localparam int MANT_W = FRAC_W + 4;
  localparam int XW     = EXP_W + 1;
  localparam int BIAS   = (1 << (EXPF_W - 1)) - 1;
  localparam int EMIN   = 1 - BIAS;
  localparam int SHW    = $clog2(MANT_W + 1);
  localparam logic signed [XW-1:0] EMIN_X = XW'(EMIN);
  localparam logic signed [XW-1:0] MW_X   = XW'(MANT_W);

  logic signed [XW-1:0] e_ext, deficit;
  logic [MANT_W:0]      rsum;
  logic [SHW-1:0]       sh;
  logic [MANT_W-1:0]    lost_mask, shifted;
  logic                 saturate, sticky;

  assign e_ext   = {exp_i[EXP_W-1], exp_i};
  assign rsum    = {1'b0, mant_i} + {{(MANT_W-3){1'b0}}, rnd_inc(sign_i, mode_i, mant_i[3:0])};
  assign tiny_o  = e_ext < EMIN_X;
  assign edge_o  = tiny_o && (e_ext == EMIN_X - XW'(1)) && rsum[MANT_W];
  assign deficit = EMIN_X - e_ext;
  assign saturate = deficit > MW_X;
  assign sh      = deficit[SHW-1:0];
  assign lost_mask = ~({MANT_W{1'b1}} << sh);
  assign sticky  = |(mant_i & lost_mask);

  always_comb begin
    if (saturate) shifted = {{(MANT_W-1){1'b0}}, |mant_i};
    else          shifted = (mant_i >> sh) | {{(MANT_W-1){1'b0}}, sticky};
  end

  always_comb begin
    mant_o = mant_i;
    exp_o  = e_ext;
    if (edge_o) begin
      mant_o = {rsum[MANT_W:4], 3'b000};
      exp_o  = EMIN_X;
    end else if (tiny_o) begin
      mant_o = shifted;
      exp_o  = EMIN_X;
    end
  end
endmodule

// File: rtl/dp_rp_round.sv
module dp_rp_round
  import dp_rp_pkg::*;
#(
  parameter int FRAC_W = 52,
  parameter int EXP_W  = 13
) (
  input  logic                     sign_i,
  input  rmode_e                   mode_i,
  input  logic signed [EXP_W:0]    exp_i,
  input  logic        [FRAC_W+3:0] mant_i,
  output logic signed [EXP_W:0]    exp_o,
  output logic        [FRAC_W:0]   frac_o,
  output logic                     inexact_o,
  output logic                     tiny_ix_o
);
  localparam int MANT_W = FRAC_W + 4;
  localparam int XW     = EXP_W + 1;

  logic [MANT_W:0] rsum;
  logic            carry;

  assign rsum      = {1'b0, mant_i} + {{(MANT_W-3){1'b0}}, rnd_inc(sign_i, mode_i, mant_i[3:0])};
  assign carry     = rsum[MANT_W];
  assign inexact_o = |mant_i[2:0];
  assign tiny_ix_o = inexact_o && !mant_i[MANT_W-1];
  assign frac_o    = carry ? rsum[MANT_W:4] : rsum[MANT_W-1:3];
  assign exp_o     = exp_i + {{(XW-1){1'b0}}, carry};
endmodule

// File: rtl/dp_rp_pack.sv
module dp_rp_pack
  import dp_rp_pkg::*;
#(
  parameter int FRAC_W = 52,
  parameter int EXPF_W = 11,
  parameter int EXP_W  = 13
) (
  input  logic                       sign_i,
  input  rmode_e                     mode_i,
  input  logic                       flush_en_i,
  input  logic                       unf_mask_i,
  input  logic                       tiny_i,
  input  logic                       edge_i,
  input  logic signed [EXP_W:0]      exp_i,
  input  logic        [FRAC_W:0]     frac_i,
  input  logic                       inexact_i,
  input  logic                       tiny_ix_i,
  output logic [FRAC_W+EXPF_W:0]     result_o,
  output logic                       inexact_o,
  output logic                       underflow_o,
  output logic                       overflow_o
);
  localparam int XW   = EXP_W + 1;
  localparam int BIAS = (1 << (EXPF_W - 1)) - 1;
  localparam logic signed [XW-1:0] EMAX_X = XW'(BIAS);
  localparam logic signed [XW-1:0] BIAS_X = XW'(BIAS);

  logic                 flush, over, toward_sign;
  logic signed [XW-1:0] biased;

  assign flush  = tiny_i && flush_en_i;
  assign over   = !flush && (exp_i > EMAX_X);
  assign biased = exp_i + BIAS_X;
  // Mode directs magnitude away from zero for this sign.
  assign toward_sign = (mode_i == RM_UP && !sign_i) || (mode_i == RM_DOWN && sign_i);

  always_comb begin
    result_o    = {sign_i, {EXPF_W{1'b0}}, frac_i[FRAC_W-1:0]};
    inexact_o   = inexact_i || edge_i;
    underflow_o = tiny_ix_i || (!frac_i[FRAC_W] && unf_mask_i);
    overflow_o  = 1'b0;
    if (flush) begin
      result_o    = {sign_i, {EXPF_W{1'b0}}, {(FRAC_W-1){1'b0}}, toward_sign};
      inexact_o   = 1'b1;
      underflow_o = 1'b1;
    end else if (over) begin
      overflow_o  = 1'b1;
      inexact_o   = 1'b1;
      underflow_o = 1'b0;
      if (mode_i == RM_NEAR || toward_sign)
        result_o = {sign_i, {EXPF_W{1'b1}}, {FRAC_W{1'b0}}};
      else
        result_o = {sign_i, {(EXPF_W-1){1'b1}}, 1'b0, {FRAC_W{1'b1}}};
    end else if (frac_i[FRAC_W]) begin
      result_o = {sign_i, biased[EXPF_W-1:0], frac_i[FRAC_W-1:0]};
    end
  end
endmodule

// File: rtl/dp_round_pack.sv
module dp_round_pack
  import dp_rp_pkg::*;
#(
  parameter int FRAC_W = 52,
  parameter int EXPF_W = 11,
  parameter int EXP_W  = 13
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        in_valid,
  input  logic                        in_sign,
  input  logic signed [EXP_W-1:0]     in_exp,
  input  logic [FRAC_W+3:0]           in_mant,
  input  logic [1:0]                  in_mode,
  input  logic                        flush_en,
  input  logic                        unf_mask,
  output logic                        out_valid,
  output logic [FRAC_W+EXPF_W:0]      out_result,
  output logic                        out_inexact,
  output logic                        out_underflow,
  output logic                        out_overflow
);
  localparam int MANT_W = FRAC_W + 4;
  localparam int XW     = EXP_W + 1;
  localparam int RES_W  = FRAC_W + EXPF_W + 1;

  logic [1:0] rst_pipe;
  logic       rst_q_n;
  rmode_e     mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_q_n = rst_pipe[1];
  assign mode    = rmode_e'(in_mode);

  logic signed [XW-1:0] t_exp, r_exp;
  logic [MANT_W-1:0]    t_mant;
  logic                 t_tiny, t_edge, r_ix, r_tix;
  logic [FRAC_W:0]      r_frac;
  logic [RES_W-1:0]     pk_result;
  logic                 pk_ix, pk_uf, pk_ov;

  dp_rp_tiny #(.FRAC_W(FRAC_W), .EXPF_W(EXPF_W), .EXP_W(EXP_W)) i_tiny (
    .sign_i(in_sign), .mode_i(mode), .exp_i(in_exp), .mant_i(in_mant),
    .exp_o(t_exp), .mant_o(t_mant), .tiny_o(t_tiny), .edge_o(t_edge));

  dp_rp_round #(.FRAC_W(FRAC_W), .EXP_W(EXP_W)) i_round (
    .sign_i(in_sign), .mode_i(mode), .exp_i(t_exp), .mant_i(t_mant),
    .exp_o(r_exp), .frac_o(r_frac), .inexact_o(r_ix), .tiny_ix_o(r_tix));

  dp_rp_pack #(.FRAC_W(FRAC_W), .EXPF_W(EXPF_W), .EXP_W(EXP_W)) i_pack (
    .sign_i(in_sign), .mode_i(mode), .flush_en_i(flush_en), .unf_mask_i(unf_mask),
    .tiny_i(t_tiny), .edge_i(t_edge), .exp_i(r_exp), .frac_i(r_frac),
    .inexact_i(r_ix), .tiny_ix_i(r_tix),
    .result_o(pk_result), .inexact_o(pk_ix), .underflow_o(pk_uf), .overflow_o(pk_ov));

  logic [RES_W-1:0] res_d, res_q;
  logic             vld_d, vld_q, ix_d, ix_q, uf_d, uf_q, ov_d, ov_q;

  always_comb begin
    vld_d = in_valid;
    res_d = res_q;
    ix_d  = ix_q;
    uf_d  = uf_q;
    ov_d  = ov_q;
    if (in_valid) begin
      res_d = pk_result;
      ix_d  = pk_ix;
      uf_d  = pk_uf;
      ov_d  = pk_ov;
    end
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      vld_q <= 1'b0;
      res_q <= '0;
      ix_q  <= 1'b0;
      uf_q  <= 1'b0;
      ov_q  <= 1'b0;
    end else begin
      vld_q <= vld_d;
      res_q <= res_d;
      ix_q  <= ix_d;
      uf_q  <= uf_d;
      ov_q  <= ov_d;
    end
  end

  assign out_valid     = vld_q;
  assign out_result    = res_q;
  assign out_inexact   = ix_q;
  assign out_underflow = uf_q;
  assign out_overflow  = ov_q;
endmodule

// File: rtl/dp_rp_chk.sv
module dp_rp_chk (
  input logic               clk,
  input logic               rst_q_n,
  input logic               in_valid,
  input logic signed [12:0] in_exp,
  input logic [55:0]        in_mant,
  input logic               flush_en,
  input logic               out_valid,
  input logic [63:0]        out_result,
  input logic               out_inexact,
  input logic               out_underflow,
  input logic               out_overflow
);
  p_valid_lat_r9: assert property (@(posedge clk) disable iff (!rst_q_n)
    in_valid |=> out_valid);
  p_idle_r9: assert property (@(posedge clk) disable iff (!rst_q_n)
    !in_valid |=> !out_valid && $stable(out_result));
  p_ovf_inexact_r4: assert property (@(posedge clk) disable iff (!rst_q_n)
    out_overflow |-> out_inexact && !out_underflow);
  p_ovf_field_r4: assert property (@(posedge clk) disable iff (!rst_q_n)
    out_overflow |-> (out_result[62:52] == 11'h7FF || out_result[62:52] == 11'h7FE));
  p_exact_r2: assert property (@(posedge clk) disable iff (!rst_q_n)
    (in_valid && in_mant[2:0] == 3'b000 && in_exp >= -13'sd1022 && in_exp <= 13'sd1023)
      |=> !out_inexact && !out_overflow);
  p_flush_r5: assert property (@(posedge clk) disable iff (!rst_q_n)
    (in_valid && flush_en && in_exp < -13'sd1022)
      |=> out_underflow && out_inexact && out_result[62:1] == 62'd0);
endmodule

bind dp_round_pack dp_rp_chk i_chk (
  .clk(clk), .rst_q_n(rst_q_n), .in_valid(in_valid), .in_exp(in_exp),
  .in_mant(in_mant), .flush_en(flush_en), .out_valid(out_valid),
  .out_result(out_result), .out_inexact(out_inexact),
  .out_underflow(out_underflow), .out_overflow(out_overflow));

// File: tb/test_dp_round_pack.sv
`timescale 1ns/1ps
module test_dp_round_pack;
  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               in_valid = 1'b0, in_sign = 1'b0, flush_en = 1'b0, unf_mask = 1'b0;
  logic signed [12:0] in_exp = '0;
  logic [55:0]        in_mant = '0;
  logic [1:0]         in_mode = '0;
  logic               out_valid, out_inexact, out_underflow, out_overflow;
  logic [63:0]        out_result;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  dp_round_pack i_dp_round_pack (.*);

  function automatic logic [56:0] inc_of(logic s, logic [1:0] md, logic [56:0] x);
    if (x[2:0] == 3'b000) return 57'd0;
    case (md)
      2'd0: return x[3] ? 57'd4 : 57'd3;
      2'd1: return 57'd0;
      2'd2: return s ? 57'd0 : 57'd8;
      default: return s ? 57'd8 : 57'd0;
    endcase
  endfunction

  // Returns {overflow, underflow, inexact, result}
  function automatic logic [66:0] expect_of(logic s, int e, logic [55:0] m, logic [1:0] md,
                                            logic fz, logic um);
    logic [56:0] x, y;
    logic ov, uf, ix, away;
    int ee, sh;
    logic [10:0] bexp;
    x = {1'b0, m}; ee = e; ov = 0; uf = 0; ix = 0;
    away = (md == 2'd2 && !s) || (md == 2'd3 && s);
    if (ee < -1022) begin
      if (fz) return {1'b0, 1'b1, 1'b1, s, 62'd0, away};
      y = x + inc_of(s, md, x);
      if (ee == -1023 && y[56]) begin
        ix = 1; x = {1'b0, y[56:1]} & ~57'd7;
      end else begin
        sh = -1022 - ee;
        if (sh > 56) x = 57'(m != 0);
        else x = (x >> sh) | 57'((x & ((57'd1 << sh) - 57'd1)) != 0);
      end
      ee = -1022;
    end
    if (x[2:0] != 3'b000) begin
      ix = 1;
      if (!x[55]) uf = 1;
      x = x + inc_of(s, md, x);
      if (x[56]) begin x = x >> 1; ee++; end
    end
    x = x >> 3;
    if (ee > 1023) begin
      if (md == 2'd0 || away) return {3'b101, s, 11'h7FF, 52'd0};
      return {3'b101, s, 11'h7FE, {52{1'b1}}};
    end
    if (!x[52]) begin
      if (um) uf = 1;
      return {ov, uf, ix, s, 11'd0, x[51:0]};
    end
    bexp = 11'(ee + 1023);
    return {ov, uf, ix, s, bexp, x[51:0]};
  endfunction

  task automatic check(string tag, logic [67:0] got, logic [67:0] exp_v);
    checks++;
    if (got !== exp_v) begin
      errors++;
      $display("FAIL %s got %h expected %h", tag, got, exp_v);
    end
  endtask

  task automatic run(string tag, logic s, int e, logic [55:0] m, logic [1:0] md,
                     logic fz, logic um);
    logic [66:0] ev;
    ev = expect_of(s, e, m, md, fz, um);
    @(negedge clk);
    in_valid = 1; in_sign = s; in_exp = 13'(e); in_mant = m;
    in_mode = md; flush_en = fz; unf_mask = um;
    @(posedge clk); #1;
    check(tag, {out_valid, out_overflow, out_underflow, out_inexact, out_result}, {1'b1, ev});
    in_valid = 0;
  endtask

  localparam logic [55:0] HID  = 56'h80_0000_0000_0000;
  localparam logic [55:0] ONES = {56{1'b1}};

  initial begin
    #(200000 * 5);
    errors++; checks++;
    $display("FAIL watchdog expired got running expected finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [66:0] held;
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    #1;
    check("R10", {out_valid, out_overflow, out_underflow, out_inexact, out_result}, 68'd0);
    @(negedge clk); rst_n = 1;
    repeat (3) @(posedge clk);

    run("R1", 0, 0, HID, 0, 0, 0);
    run("R1", 1, -1022, HID | 56'h8, 1, 0, 1);
    run("R1", 0, 1023, ONES & ~56'h7, 0, 0, 0);
    for (int md = 0; md < 4; md++) begin
      run("R2", 0, 5, HID | 56'h4, 2'(md), 0, 0);
      run("R2", 1, 5, HID | 56'hC, 2'(md), 0, 0);
      run("R2", 0, -7, HID | 56'h1, 2'(md), 0, 0);
      run("R2", 1, 9, HID | 56'h5, 2'(md), 0, 0);
    end
    run("R3", 0, 10, ONES, 0, 0, 0);
    run("R3", 0, 10, ONES, 2, 0, 0);
    run("R3", 1, 10, ONES, 3, 0, 0);
    for (int md = 0; md < 4; md++) begin
      run("R4", 0, 2000, HID | 56'h3, 2'(md), 0, 0);
      run("R4", 1, 2000, HID, 2'(md), 0, 0);
      run("R5", 0, -1030, HID, 2'(md), 1, 0);
      run("R5", 1, -4096, ONES, 2'(md), 1, 1);
    end
    run("R4", 0, 1023, ONES, 0, 0, 0);
    run("R6", 0, -1023, ONES, 0, 0, 0);
    run("R6", 1, -1023, ONES & ~56'h7 | 56'h1, 3, 0, 1);
    run("R7", 0, -1023, ONES, 1, 0, 0);
    run("R7", 0, -1030, HID | 56'h1, 0, 0, 0);
    run("R7", 0, -4096, HID, 2, 0, 0);
    run("R7", 1, -1080, ONES, 3, 0, 0);
    run("R7", 0, -1076, HID, 0, 0, 0);
    run("R8", 0, -1023, HID, 0, 0, 0);
    run("R8", 0, -1023, HID, 0, 0, 1);

    held = expect_of(1, 3, HID | 56'h9, 0, 0, 0);
    run("R9", 1, 3, HID | 56'h9, 0, 0, 0);
    @(negedge clk);
    in_sign = 0; in_exp = 13'sd2000; in_mant = ONES; flush_en = 1;
    @(posedge clk); #1;
    check("R9", {out_valid, out_overflow, out_underflow, out_inexact, out_result}, {1'b0, held});

    for (int i = 0; i < 3000; i++) begin
      int e;
      logic [55:0] m;
      logic [66:0] ev;
      string tag;
      logic s, fz, um;
      logic [1:0] md;
      case ($urandom % 6)
        0: e = int'($urandom % 2046) - 1022;
        1: e = int'($urandom % 12) + 1018;
        2: e = int'($urandom % 14) - 1030;
        3: e = int'($urandom % 40) - 1100;
        4: e = -int'($urandom % 2800) - 1200;
        default: e = int'($urandom % 3000) + 1024;
      endcase
      m = {$urandom, $urandom} & ONES | HID;
      if ($urandom % 4 == 0) m = m | 56'h7F_FFFF_FFFF_FFF0;
      if ($urandom % 4 == 0) m = m & ~56'h7;
      s = 1'($urandom); md = 2'($urandom); fz = ($urandom % 4 == 0); um = 1'($urandom);
      ev = expect_of(s, e, m, md, fz, um);
      if (e < -1022 && fz) tag = "R5";
      else if (ev[66]) tag = "R4";
      else if (e < -1022) tag = "R7";
      else if (ev[64]) tag = "R2";
      else tag = "R1";
      run(tag, s, e, m, md, fz, um);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule